// File: doc/BRIEF.md
# SPI Register-File Slave for a Real-Time Clock

This block is the host-facing serial port of a real-time-clock macro. A host reaches a 128-address byte map over a four-wire serial link. The map holds the time and date bytes, two alarm comparands, a control byte, a status byte, a configuration byte and 96 bytes of general-purpose scratch storage. Counting the time and matching the alarms belong to neighbouring blocks. This block decodes addresses, stores bytes and serves reads. It also applies the write lock and the fixed-zero bit fields.

Each transfer is framed by an active-high chip select. The first byte of a frame is a command byte: its most significant bit picks write (1) or read (0), and its low seven bits give the starting address. Every later byte in the same frame goes to the next address, or comes from it. The counter steps past 0x7F to 0x00. The serial clock is expected to be much slower than the system clock. The chip select, serial clock and data input are synchronised into the system domain and their edges are detected there.

Internally, received bytes pass from the shifter to the register file as a valid-only stream, and read bytes pass back as a single-cycle load strobe. Neither path has back-pressure. A serial master cannot be stalled, so the register file accepts one byte per valid pulse and returns a read byte within two system cycles.

Top module: `rtc_spi_regs`

## Requirements
- R1: While chip select is high, the first 8 bits form a command byte. Bit 7 = 1 selects a write and bit 7 = 0 selects a read. Bits 6:0 give the start address. Data bytes sent during a read frame change nothing.
- R2: The serial mode uses clock polarity 0 and clock phase 1, most significant bit first. The data input is sampled on the falling serial-clock edge. The data output changes only on a rising edge, and it stays 0 during the command byte.
- R3: Chip select is active high. While it is low, serial-clock activity changes no register and the data output stays 0.
- R4: In one frame, each data byte after the command byte targets the address one above the previous byte's address, for both reads and writes.
- R5: The address counter wraps from 0x7F to 0x00 within a burst.
- R6: Bit 6 of the control byte (address 0x0F) is a write lock. While it is 1, writes to every address other than 0x0F are ignored. The control byte itself stays writable.
- R7: Bits 5:3 of the control byte always read 0. Its other bits store what was written. The stored control byte is driven on `ctrl_value`.
- R8: The status byte (0x10) reads as {6'b0, alarm_flags[1:0]}. Host writes to it are ignored.
- R9: Addresses 0x12 to 0x1F read as 0x00. Writes to them are ignored.
- R10: Addresses 0x00 to 0x0E, 0x11 and 0x20 to 0x7F store and return full 8-bit values.
- R11: If chip select drops before the 8th bit of a byte, that byte is discarded. Bytes already completed in the frame are kept, and the next frame starts with a fresh command byte.
- R12: After reset, every stored byte and the control byte are 0x00, and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs | input | 1 | Chip select, active high |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, driven 0 when idle |
| alarm_flags | input | 2 | Live alarm flags from the alarm block, shown in status bits 1:0 |
| ctrl_value | output | 8 | Stored control byte, for neighbouring blocks |

## Verification
The bench targets the boundaries of the address map:
- A burst crossing 0x7F must land its third byte at 0x00. A counter that saturated, or carried into bit 7, would corrupt a different byte.
- Writes to the gap at 0x12 to 0x1F and to the status byte must read back as zero and as the flag inputs. A design that stored them would echo the written value.

The write lock is toggled through the control byte, so a design that locked the control byte itself could never be unlocked. Frames cut mid-byte check that a half-shifted byte is discarded and that the next command byte still aligns. A bit counter that survived chip-select loss would misread every later frame.

// File: rtl/rsr_pkg.sv
package rsr_pkg;

  localparam int BYTE_W     = 8;
  localparam int ADDR_W     = 7;
  localparam int FLAG_W     = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 7'h0F;
  localparam logic [ADDR_W-1:0] A_STAT   = 7'h10;
  localparam logic [ADDR_W-1:0] A_CFG    = 7'h11;
  localparam logic [ADDR_W-1:0] A_RAM_LO = 7'h20;

  // Control byte: bit 6 is the write lock, bits 5:3 are fixed at zero.
  localparam int               LOCK_BIT  = 6;
  localparam logic [BYTE_W-1:0] CTRL_KEEP = 8'hC7;

  typedef enum logic [1:0] {
    KIND_PLAIN,   // ordinary read/write byte
    KIND_CTRL,    // control byte, masked, exempt from the lock
    KIND_STAT,    // status byte, read-only mirror of the flags
    KIND_HOLE     // unmapped gap
  } kind_e;

  function automatic kind_e addr_kind(input logic [ADDR_W-1:0] a);
    if (a == A_CTRL)                              return KIND_CTRL;
    else if (a == A_STAT)                         return KIND_STAT;
    else if (a < A_CTRL || a == A_CFG || a >= A_RAM_LO) return KIND_PLAIN;
    else                                          return KIND_HOLE;
  endfunction

endpackage

// File: rtl/rsr_sync.sv
module rsr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/rsr_serial.sv
module rsr_serial #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              mosi_s,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              tx_load,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              rx_first,
  output logic              miso
);

  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  logic              sclk_d;
  logic              rise, fall;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              first_q;
  logic [BYTE_W-1:0] tx_q;
  logic              miso_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign rise = cs_s &  sclk_s & ~sclk_d;
  assign fall = cs_s & ~sclk_s &  sclk_d;

  // Receive side: sample on the falling edge, MSB first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt_q <= '0;
      shift_q   <= '0;
      first_q   <= 1'b1;
      rx_valid  <= 1'b0;
      rx_byte   <= '0;
      rx_first  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (!cs_s) begin
        bit_cnt_q <= '0;
        first_q   <= 1'b1;
      end else if (fall) begin
        shift_q <= {shift_q[BYTE_W-2:0], mosi_s};
        if (bit_cnt_q == LAST_BIT) begin
          bit_cnt_q <= '0;
          rx_valid  <= 1'b1;
          rx_byte   <= {shift_q[BYTE_W-2:0], mosi_s};
          rx_first  <= first_q;
          first_q   <= 1'b0;
        end else begin
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
      end
    end
  end

  // Transmit side: next bit leaves on each rising edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (!cs_s) begin
      tx_q   <= '0;
      miso_q <= 1'b0;
    end else if (tx_load) begin
      tx_q <= tx_byte;
    end else if (rise) begin
      miso_q <= tx_q[BYTE_W-1];
      tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign miso = miso_q;

  // R3: a deselected port emits nothing
  p_idle_when_deselected_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |=> (!rx_valid && !miso))
    else $error("deselected port produced activity");

  // R2: output changes only after a rising serial edge
  p_miso_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && $past(cs_s) && !$past(rise)) |-> $stable(miso_q))
    else $error("miso moved without a rising edge");

  // R2: completed bytes only follow a falling serial edge
  p_rx_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(fall))
    else $error("byte completed without a falling edge");

endmodule

// File: rtl/rsr_regfile.sv
module rsr_regfile
  import rsr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = BYTE_W,
  parameter int FW = FLAG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_first,
  input  logic [FW-1:0] alarm_flags,
  output logic [DW-1:0] tx_byte,
  output logic          tx_load,
  output logic [DW-1:0] ctrl_value
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0][DW-1:0] mem_q;
  logic [AW-1:0]            addr_q;
  logic                     wr_mode_q;
  logic                     fetch_q;
  kind_e                    kind;
  logic                     locked;
  logic                     wr_fire;

  assign kind    = addr_kind(addr_q);
  assign locked  = mem_q[A_CTRL][LOCK_BIT];
  assign wr_fire = rx_valid & ~rx_first & wr_mode_q;

  // Address counter, mode and read prefetch control.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q    <= '0;
      wr_mode_q <= 1'b0;
      fetch_q   <= 1'b0;
    end else begin
      fetch_q <= 1'b0;
      if (rx_valid && rx_first) begin
        addr_q    <= rx_byte[AW-1:0];
        wr_mode_q <= rx_byte[DW-1];
        fetch_q   <= ~rx_byte[DW-1];
      end else if (wr_fire) begin
        addr_q <= addr_q + 1'b1;
      end else if (rx_valid) begin
        fetch_q <= 1'b1;
      end else if (fetch_q) begin
        addr_q <= addr_q + 1'b1;
      end
    end
  end

  // Storage with region-dependent write rules.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
    end else if (wr_fire) begin
      unique case (kind)
        KIND_PLAIN: if (!locked) mem_q[addr_q] <= rx_byte;
        KIND_CTRL:  mem_q[A_CTRL] <= rx_byte & CTRL_KEEP;
        default:    ;
      endcase
    end
  end

  always_comb begin
    unique case (kind)
      KIND_PLAIN: tx_byte = mem_q[addr_q];
      KIND_CTRL:  tx_byte = mem_q[A_CTRL];
      KIND_STAT:  tx_byte = {{(DW-FW){1'b0}}, alarm_flags};
      default:    tx_byte = '0;
    endcase
  end

  assign tx_load    = fetch_q;
  assign ctrl_value = mem_q[A_CTRL];

  // R6: a locked write outside the control byte leaves storage alone
  p_lock_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && locked && kind != KIND_CTRL) |=> $stable(mem_q))
    else $error("write went through the lock");

  // R8: status writes do not reach storage
  p_status_ro_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && kind == KIND_STAT) |=> $stable(mem_q))
    else $error("status write stored");

  // R9: gap writes do not reach storage, gap reads are zero
  p_hole_ro_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && kind == KIND_HOLE) |=> $stable(mem_q))
    else $error("gap write stored");

  p_hole_reads_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && kind == KIND_HOLE) |-> (tx_byte == '0))
    else $error("gap read non-zero");

  // R7: fixed-zero control bits never show up on a read
  p_ctrl_rsvd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_q && kind == KIND_CTRL) |-> (tx_byte[5:3] == 3'b000))
    else $error("reserved control bits non-zero");

  // R4/R5: each written byte steps the address by one, modulo the map size
  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (addr_q == AW'($past(addr_q) + 1'b1)))
    else $error("address did not step");

endmodule

// File: rtl/rtc_spi_regs.sv
module rtc_spi_regs
  import rsr_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic [FLAG_W-1:0] alarm_flags,
  output logic [BYTE_W-1:0] ctrl_value
);

  logic [2:0]        pins_s;
  logic              rx_valid;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_first;
  logic [BYTE_W-1:0] tx_byte;
  logic              tx_load;

  rsr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({spi_cs, spi_sclk, spi_mosi}),
    .q     (pins_s)
  );

  rsr_serial #(.BYTE_W(BYTE_W)) u_serial (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_s     (pins_s[2]),
    .sclk_s   (pins_s[1]),
    .mosi_s   (pins_s[0]),
    .tx_byte  (tx_byte),
    .tx_load  (tx_load),
    .rx_valid (rx_valid),
    .rx_byte  (rx_byte),
    .rx_first (rx_first),
    .miso     (spi_miso)
  );

  rsr_regfile #(.AW(ADDR_W), .DW(BYTE_W), .FW(FLAG_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_valid    (rx_valid),
    .rx_byte     (rx_byte),
    .rx_first    (rx_first),
    .alarm_flags (alarm_flags),
    .tx_byte     (tx_byte),
    .tx_load     (tx_load),
    .ctrl_value  (ctrl_value)
  );

  // R7: the exported control byte never carries the fixed-zero bits
  p_ctrl_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ctrl_value) |-> (ctrl_value[5:3] == 3'b000))
    else $error("control output reserved bits set");

endmodule

// File: tb/rtc_spi_regs_bench.sv
module rtc_spi_regs_bench;

  localparam int HALF = 8;
  localparam int WD_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       spi_cs, spi_sclk, spi_mosi;
  logic       spi_miso;
  logic [1:0] alarm_flags;
  logic [7:0] ctrl_value;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rtc_spi_regs u_rtc_spi_regs (
    .clk (clk), .rst_n (rst_n), .spi_cs (spi_cs), .spi_sclk (spi_sclk),
    .spi_mosi (spi_mosi), .spi_miso (spi_miso),
    .alarm_flags (alarm_flags), .ctrl_value (ctrl_value)
  );

  // {address, written byte, expected read-back}
  localparam logic [23:0] VEC [10] = '{
    {8'h00, 8'h59, 8'h59},   // R10 time byte
    {8'h06, 8'h99, 8'h99},   // R10
    {8'h0E, 8'hA5, 8'hA5},   // R10 last alarm byte
    {8'h11, 8'hA9, 8'hA9},   // R10 config byte
    {8'h20, 8'h3C, 8'h3C},   // R10 first RAM byte
    {8'h7F, 8'hC3, 8'hC3},   // R10 last RAM byte
    {8'h15, 8'h5A, 8'h00},   // R9 gap
    {8'h10, 8'hFF, 8'h02},   // R8 status with flags 2'b10
    {8'h0F, 8'h3F, 8'h07},   // R7 control mask
    {8'h0F, 8'h00, 8'h00}    // R7 control cleared
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int b = 7; b >= 0; b--) begin
      spi_mosi = tx[b];
      spi_sclk = 1'b1;
      tick(HALF);
      rx[b] = spi_miso;
      spi_sclk = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic partial(input logic [7:0] tx, input int nbits);
    for (int b = 7; b > 7 - nbits; b--) begin
      spi_mosi = tx[b];
      spi_sclk = 1'b1;
      tick(HALF);
      spi_sclk = 1'b0;
      tick(HALF);
    end
  endtask

  task automatic cs_on();
    spi_cs = 1'b1;
    tick(HALF);
  endtask

  task automatic cs_off();
    tick(HALF);
    spi_cs = 1'b0;
    tick(2 * HALF);
  endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] d);
    logic [7:0] junk;
    cs_on();
    xfer({1'b1, a}, junk);
    xfer(d, junk);
    cs_off();
  endtask

  task automatic rd1(input logic [6:0] a, output logic [7:0] d);
    logic [7:0] junk;
    cs_on();
    xfer({1'b0, a}, junk);
    xfer(8'h00, d);
    cs_off();
  endtask

  initial begin
    logic [7:0] r0, r1, r2, r3;
    spi_cs = 0; spi_sclk = 0; spi_mosi = 0; alarm_flags = 2'b10;
    rst_n = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);

    // R12 reset state
    check("R12 ctrl_value after reset", ctrl_value, 8'h00);
    check("R12 miso after reset", {7'd0, spi_miso}, 8'h00);
    rd1(7'h05, r0); check("R12 time byte after reset", r0, 8'h00);
    rd1(7'h20, r0); check("R12 RAM byte after reset", r0, 8'h00);

    // Table walk: single-byte write, then read back
    for (int i = 0; i < 10; i++) begin
      wr1(VEC[i][22:16], VEC[i][15:8]);
      rd1(VEC[i][22:16], r0);
      check($sformatf("R7-R10 vector %0d", i), r0, VEC[i][7:0]);
    end
    check("R7 ctrl_value after clear", ctrl_value, 8'h00);

    // R2 miso idle during command byte; R1 read path
    cs_on(); xfer(8'h20, r0); xfer(8'h00, r1); cs_off();
    check("R2 miso during command byte", r0, 8'h00);
    check("R1 read returns stored byte", r1, 8'h3C);

    // R1 data sent inside a read frame is not stored
    cs_on(); xfer(8'h20, r0); xfer(8'hEE, r0); xfer(8'hEE, r0); cs_off();
    rd1(7'h20, r0); check("R1 read frame left byte intact", r0, 8'h3C);

    // R4 burst write then burst read
    cs_on(); xfer(8'h81, r0); xfer(8'h11, r0); xfer(8'h22, r0); xfer(8'h33, r0); cs_off();
    cs_on(); xfer(8'h01, r0); xfer(0, r1); xfer(0, r2); xfer(0, r3); cs_off();
    check("R4 burst byte 0", r1, 8'h11);
    check("R4 burst byte 1", r2, 8'h22);
    check("R4 burst byte 2", r3, 8'h33);

    // R5 wrap past 0x7F
    cs_on(); xfer(8'hFE, r0); xfer(8'hAA, r0); xfer(8'hBB, r0); xfer(8'hCC, r0); cs_off();
    rd1(7'h00, r0); check("R5 write wrapped to 0x00", r0, 8'hCC);
    cs_on(); xfer(8'h7E, r0); xfer(0, r1); xfer(0, r2); xfer(0, r3); cs_off();
    check("R5 read 0x7E", r1, 8'hAA);
    check("R5 read 0x7F", r2, 8'hBB);
    check("R5 read wrapped 0x00", r3, 8'hCC);

    // R8 status follows the live flags
    alarm_flags = 2'b01;
    tick(4);
    rd1(7'h10, r0); check("R8 status mirrors flags", r0, 8'h01);

    // R6 write lock
    wr1(7'h0F, 8'h40);
    check("R6 lock set on ctrl_value", ctrl_value, 8'h40);
    wr1(7'h20, 8'h22);
    rd1(7'h20, r0); check("R6 locked RAM write ignored", r0, 8'h3C);
    wr1(7'h11, 8'h00);
    rd1(7'h11, r0); check("R6 locked config write ignored", r0, 8'hA9);
    wr1(7'h0F, 8'hFF);
    check("R6 R7 control writable under lock", ctrl_value, 8'hC7);
    wr1(7'h0F, 8'h00);
    check("R6 lock released", ctrl_value, 8'h00);
    wr1(7'h20, 8'h22);
    rd1(7'h20, r0); check("R6 unlocked write stored", r0, 8'h22);

    // R11 abort mid-byte
    cs_on(); xfer(8'hB0, r0); xfer(8'h77, r0); partial(8'hFF, 4);
    spi_cs = 1'b0; tick(2 * HALF);
    rd1(7'h30, r0); check("R11 completed byte kept", r0, 8'h77);
    rd1(7'h31, r0); check("R11 partial byte discarded", r0, 8'h00);
    cs_on(); partial(8'hA1, 5); spi_cs = 1'b0; tick(2 * HALF);
    rd1(7'h30, r0); check("R11 framing realigned", r0, 8'h77);

    // R3 clocking while deselected
    begin
      logic [7:0] seen;
      seen = 8'h00;
      for (int k = 0; k < 16; k++) begin
        spi_mosi = 1'b1; spi_sclk = 1'b1; tick(HALF);
        seen[0] = seen[0] | spi_miso;
        spi_sclk = 1'b0; tick(HALF);
      end
      check("R3 miso quiet while deselected", seen, 8'h00);
    end
    rd1(7'h7F, r0); check("R3 no write while deselected", r0, 8'hBB);
    check("R3 control untouched while deselected", ctrl_value, 8'h00);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule